// File: doc/BRIEF.md
# Carry-Chain Tap Snapshot Decoder

This block turns a registered snapshot of a tapped delay line into a fine time count. A start edge travels along a chain of buffers, and each tap output is captured by its own flip-flop when the stop edge, or the chosen phase clock, arrives. The captured word looks like a thermometer code. Real lines do not give a clean one, though. Adjacent taps inside one logic cell tend to switch in pairs, and isolated bubbles appear. The decoder counts the ones in the word and reports that number as the count of taps the edge has passed. It raises an overflow flag when every tap has switched, which means the edge ran past the end of the line.

Four such lines exist, one for each quarter-period clock phase. A phase detector outside the block supplies a line index. With that index the block picks which of the four snapshots is decoded. A new snapshot can be presented on every clock cycle. The result appears two cycles later with its own valid strobe.

Top module: `tdl_therm_decoder`

## Requirements
- R1: While reset is asserted and after it is released, until the first valid snapshot is decoded, `fine_vld_o`, `fine_cnt_o` and `fine_ovf_o` are all zero.
- R2: The snapshot of line k occupies bits `[k*NUM_TAPS +: NUM_TAPS]` of `snap_i`. With `line_sel_i` = k, only that slice affects the result, and the contents of the other lines are ignored.
- R3: `fine_cnt_o` equals the number of ones in the selected snapshot, whatever their positions, so paired and bubbled transitions are counted without error. It never exceeds `NUM_TAPS`.
- R4: When every bit of the selected snapshot is 1, `fine_ovf_o` is 1 and `fine_cnt_o` equals `NUM_TAPS`. For any other snapshot, `fine_ovf_o` is 0.
- R5: An all-zero selected snapshot yields `fine_cnt_o` = 0 with `fine_ovf_o` = 0.
- R6: A snapshot presented with `snap_vld_i` high at rising edge k produces its result at rising edge k+1. At that edge `fine_vld_o` is high for exactly one cycle per accepted snapshot.
- R7: Snapshots on consecutive cycles are all accepted and decoded in order, with no dead cycle.
- R8: While `snap_vld_i` is low, `snap_i` and `line_sel_i` are ignored. Once the pipeline drains, `fine_cnt_o` and `fine_ovf_o` keep their last values and `fine_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| snap_vld_i | input | 1 | Snapshot words are valid this cycle |
| line_sel_i | input | SEL_W (2) | Index of the delay line to decode, from the phase detector |
| snap_i | input | NUM_LINES*NUM_TAPS (144) | Tap snapshots of all lines; line k in bits [k*NUM_TAPS +: NUM_TAPS] |
| fine_vld_o | output | 1 | Decoded result valid strobe |
| fine_cnt_o | output | CNT_W (6) | Number of taps the start edge has passed |
| fine_ovf_o | output | 1 | Every tap switched: edge beyond line length |

## Verification
The assertions assume that `line_sel_i` names an existing line whenever `snap_vld_i` is high, and that `snap_vld_i` is held low while reset is asserted. The stimulus drives only the indices 0 to 3 and keeps the valid input low during reset. All inputs change on the falling clock edge, so each one is stable at the rising edge that samples it. The idle cycles between scenarios deliberately carry random-looking snapshot data and out-of-pattern indices with valid low. This data stays away from the cycles in which valid is high.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  // Default geometry: line of about 454 ps at about 13 ps per buffer.
  localparam int unsigned TDL_TAPS_DEF  = 36;
  localparam int unsigned TDL_LINES_DEF = 4;
endpackage

// File: rtl/tdl_line_select.sv
// Stage 1: choose one phase line's snapshot and register it.
module tdl_line_select #(
  parameter int unsigned NUM_TAPS  = tdl_pkg::TDL_TAPS_DEF,
  parameter int unsigned NUM_LINES = tdl_pkg::TDL_LINES_DEF,
  parameter int unsigned SEL_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           vld_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [NUM_LINES*NUM_TAPS-1:0]  snap_i,
  output logic                           vld_o,
  output logic [NUM_TAPS-1:0]            snap_o
);
  logic [NUM_TAPS-1:0] line_w [NUM_LINES];
  logic [NUM_TAPS-1:0] snap_d, snap_q;
  logic                vld_d, vld_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign line_w[g] = snap_i[g*NUM_TAPS +: NUM_TAPS];
  end

  always_comb begin
    vld_d  = vld_i;
    snap_d = snap_q;
    if (vld_i) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (sel_i == SEL_W'(i)) snap_d = line_w[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (vld_i) snap_q <= snap_d;
    end
  end

  assign vld_o  = vld_q;
  assign snap_o = snap_q;

  assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (int'(sel_i) < NUM_LINES));

  assert_accept_each_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (vld_o == $past(vld_i)));
endmodule

// File: rtl/tdl_ones_count.sv
// Combinational ones-count over the selected tap word.
module tdl_ones_count #(
  parameter int unsigned NUM_TAPS = tdl_pkg::TDL_TAPS_DEF,
  parameter int unsigned CNT_W    = $clog2(NUM_TAPS + 1)
) (
  input  logic [NUM_TAPS-1:0] taps_i,
  output logic [CNT_W-1:0]    ones_o,
  output logic                full_o
);
  always_comb begin
    ones_o = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      ones_o = ones_o + CNT_W'(taps_i[i]);
    end
  end

  assign full_o = &taps_i;
endmodule

// File: rtl/tdl_therm_decoder.sv
// Top: two-stage tap snapshot decoder.
module tdl_therm_decoder #(
  parameter int unsigned NUM_TAPS  = tdl_pkg::TDL_TAPS_DEF,
  parameter int unsigned NUM_LINES = tdl_pkg::TDL_LINES_DEF,
  localparam int unsigned SEL_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned CNT_W    = $clog2(NUM_TAPS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          snap_vld_i,
  input  logic [SEL_W-1:0]              line_sel_i,
  input  logic [NUM_LINES*NUM_TAPS-1:0] snap_i,
  output logic                          fine_vld_o,
  output logic [CNT_W-1:0]              fine_cnt_o,
  output logic                          fine_ovf_o
);
  logic                s1_vld;
  logic [NUM_TAPS-1:0] s1_snap;
  logic [CNT_W-1:0]    ones_w;
  logic                full_w;

  logic             vld_d, vld_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             ovf_d, ovf_q;

  tdl_line_select #(
    .NUM_TAPS (NUM_TAPS),
    .NUM_LINES(NUM_LINES),
    .SEL_W    (SEL_W)
  ) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (snap_vld_i),
    .sel_i (line_sel_i),
    .snap_i(snap_i),
    .vld_o (s1_vld),
    .snap_o(s1_snap)
  );

  tdl_ones_count #(
    .NUM_TAPS(NUM_TAPS),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .taps_i(s1_snap),
    .ones_o(ones_w),
    .full_o(full_w)
  );

  always_comb begin
    vld_d = s1_vld;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (s1_vld) begin
      cnt_d = ones_w;
      ovf_d = full_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (s1_vld) begin
        cnt_q <= cnt_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign fine_vld_o = vld_q;
  assign fine_cnt_o = cnt_q;
  assign fine_ovf_o = ovf_q;

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fine_cnt_o) <= NUM_TAPS);

  assert_ovf_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fine_ovf_o |-> (int'(fine_cnt_o) == NUM_TAPS));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fine_vld_o == $past(s1_vld)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> ($stable(fine_cnt_o) && $stable(fine_ovf_o)));
endmodule

// File: tb/tdl_therm_decoder_tb.sv
`timescale 1ns/1ps
module tdl_therm_decoder_tb;
  localparam int TAPS  = 36;
  localparam int LINES = 4;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  snap_vld_i;
  logic [1:0]            line_sel_i;
  logic [LINES*TAPS-1:0] snap_i;
  logic                  fine_vld_o;
  logic [5:0]            fine_cnt_o;
  logic                  fine_ovf_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tdl_therm_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .snap_vld_i(snap_vld_i), .line_sel_i(line_sel_i),
    .snap_i(snap_i), .fine_vld_o(fine_vld_o), .fine_cnt_o(fine_cnt_o),
    .fine_ovf_o(fine_ovf_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [TAPS-1:0] w);
    int n = 0;
    for (int i = 0; i < TAPS; i++) if (w[i]) n++;
    return n;
  endfunction

  function automatic logic [TAPS-1:0] therm(input int n);
    logic [TAPS-1:0] w = '0;
    for (int i = 0; i < n; i++) w[i] = 1'b1;
    return w;
  endfunction

  function automatic logic [LINES*TAPS-1:0] pack(input logic [TAPS-1:0] l0,
      input logic [TAPS-1:0] l1, input logic [TAPS-1:0] l2, input logic [TAPS-1:0] l3);
    return {l3, l2, l1, l0};
  endfunction

  // One snapshot, then an idle cycle with junk data to show it is ignored.
  task automatic t_single(input string req, input logic [1:0] sel,
                          input logic [LINES*TAPS-1:0] bus);
    logic [TAPS-1:0] w;
    int exp_cnt;
    bit exp_ovf;
    w = bus[sel*TAPS +: TAPS];
    exp_cnt = ones(w);
    exp_ovf = (w == {TAPS{1'b1}});
    @(negedge clk);
    snap_vld_i = 1'b1; line_sel_i = sel; snap_i = bus;
    @(negedge clk);
    snap_vld_i = 1'b0; line_sel_i = ~sel; snap_i = {4{36'h5A5A5A5A5}};
    @(negedge clk);
    chk(fine_vld_o == 1'b1, "R6", "vld", fine_vld_o, 1);
    chk(fine_cnt_o == 6'(exp_cnt), req, "cnt", fine_cnt_o, exp_cnt);
    chk(fine_ovf_o == exp_ovf, req, "ovf", fine_ovf_o, exp_ovf);
    snap_i = {4{36'hFFFFFFFFF}};
    @(negedge clk);
    chk(fine_vld_o == 1'b0, "R8", "vld idle", fine_vld_o, 0);
    chk(fine_cnt_o == 6'(exp_cnt), "R8", "cnt hold", fine_cnt_o, exp_cnt);
    chk(fine_ovf_o == exp_ovf, "R8", "ovf hold", fine_ovf_o, exp_ovf);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; snap_vld_i = 1'b0; line_sel_i = '0; snap_i = '1;
    repeat (3) @(negedge clk);
    chk(fine_vld_o == 0 && fine_cnt_o == 0 && fine_ovf_o == 0, "R1", "in reset",
        {fine_vld_o, fine_ovf_o, fine_cnt_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(fine_vld_o == 0 && fine_cnt_o == 0 && fine_ovf_o == 0, "R1", "after release",
        {fine_vld_o, fine_ovf_o, fine_cnt_o}, 0);
  endtask

  task automatic t_select_each();
    for (int k = 0; k < LINES; k++) begin
      logic [TAPS-1:0] l [LINES];
      for (int j = 0; j < LINES; j++) l[j] = (j == k) ? therm(5 + 7*k) : '1;
      t_single("R2", 2'(k), pack(l[0], l[1], l[2], l[3]));
    end
  endtask

  task automatic t_bubbles();
    logic [TAPS-1:0] w;
    w = therm(20);
    w[20] = 1'b1; w[21] = 1'b1; w[19] = 1'b0;   // paired step with bubble
    t_single("R3", 2'd1, pack('1, w, '0, '1));
    w = therm(28);
    w[3] = 1'b0; w[30] = 1'b1;                 // isolated bubbles
    t_single("R3", 2'd3, pack('0, '0, '1, w));
  endtask

  task automatic t_edges();
    t_single("R5", 2'd2, pack('1, '1, '0, '1));
    t_single("R4", 2'd0, pack('1, '0, '0, '0));
    t_single("R4", 2'd1, pack('0, therm(35), '1, '1));
  endtask

  task automatic t_stream();
    logic [LINES*TAPS-1:0] bus [4];
    logic [1:0] sel [4];
    int exp_c [4];
    bit exp_o [4];
    for (int i = 0; i < 4; i++) begin
      sel[i] = 2'(3 - i);
      bus[i] = pack(therm(4 + i), therm(10 + 3*i), therm(i == 1 ? 36 : 20 - i), therm(30 + i));
      exp_c[i] = ones(bus[i][sel[i]*TAPS +: TAPS]);
      exp_o[i] = (exp_c[i] == TAPS);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk(fine_vld_o == 1'b1, "R7", "stream vld", fine_vld_o, 1);
        chk(fine_cnt_o == 6'(exp_c[i-2]), "R7", "stream cnt", fine_cnt_o, exp_c[i-2]);
        chk(fine_ovf_o == exp_o[i-2], "R7", "stream ovf", fine_ovf_o, exp_o[i-2]);
      end
      if (i < 4) begin
        snap_vld_i = 1'b1; line_sel_i = sel[i]; snap_i = bus[i];
      end else begin
        snap_vld_i = 1'b0;
      end
    end
    @(negedge clk);
    chk(fine_vld_o == 1'b0, "R6", "stream end vld", fine_vld_o, 0);
  endtask

  initial begin
    t_reset();
    t_select_each();
    t_bubbles();
    t_edges();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R6 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule